// File: doc/BRIEF.md
# PRBS Bit Error Rate Tester Core

This block drives a pseudo-random serial test stream and checks a returned stream against that pattern to measure bit errors on a link. The transmitter is a shift-register pattern source. Three maximal-length orders are available, and the bit rate is set by a divider that produces a one-cycle bit strobe in one of eight steps. A single-cycle request corrupts exactly one outgoing bit, so the whole path can be proven live.

The receiver first hunts for the pattern by shifting received bits into its own register. After a run of correct predictions it declares lock. From then on it runs its register on its own predictions, so that each corrupted line bit counts as exactly one error. Two saturating counters, one for errors and one for bits, advance only while the receiver is locked. Their ratio gives the error rate.

Top module: `prbs_bert_core`

## Requirements
- R1: The transmitted bit sequence follows b[n] = b[n-9] ^ b[n-5] for `pattern_sel` 00, b[n] = b[n-15] ^ b[n-14] for 01, and b[n] = b[n-23] ^ b[n-18] for 10 and 11. The history is all ones after reset and after every pattern change, so the first emitted bit is 0.
- R2: `tx_valid` is a one-cycle pulse. Consecutive pulses are (8 - `rate_sel`) * DIV_STEP clock cycles apart, so level 7 is the fastest.
- R3: An `inject` pulse is held until the next bit strobe. Exactly that one transmitted bit is inverted, and all later bits continue the undisturbed sequence.
- R4: With `rx_data`/`rx_valid` looped back from the transmitter, `locked` asserts once 32 consecutive received bits match the predicted bit.
- R5: While locked, each single inverted received bit raises `err_count` by exactly one.
- R6: While locked, 8 mispredicted bits inside one aligned block of 64 received bits drop `locked`. The receiver then hunts again and relocks on a clean stream.
- R7: `bit_count` rises by one for each received strobe while `locked` is high. Neither counter moves while `locked` is low.
- R8: Both counters stop at all ones instead of wrapping, and `err_count` never exceeds `bit_count`.
- R9: `clr_counts` zeroes both counters on the next clock edge and takes priority over counting.
- R10: A change of `pattern_sel` drops `locked` on the next clock edge and restarts the transmitter from its seed.
- R11: During reset `tx_valid`, `locked`, `err_count` and `bit_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pattern_sel | input | 2 | Sequence order: 00 short, 01 medium, 10/11 long |
| rate_sel | input | 3 | Bit-rate step, 7 fastest |
| inject | input | 1 | Request to invert one transmitted bit |
| tx_data | output | 1 | Transmitted serial bit |
| tx_valid | output | 1 | Strobe marking a new transmitted bit |
| rx_data | input | 1 | Received serial bit |
| rx_valid | input | 1 | Strobe marking a received bit |
| clr_counts | input | 1 | Synchronous clear of both counters |
| locked | output | 1 | Receiver synchronised to the pattern |
| err_count | output | CNT_W | Saturating count of mispredicted bits while locked |
| bit_count | output | CNT_W | Saturating count of received bits while locked |

## Verification
The transmitted stream of each of the three orders is compared bit by bit against an arithmetic model started from the all-ones history. This tells a wrong tap or a wrong seed apart from a correct sequence, and the short order runs past its full 511-bit period. A clean loopback shows lock and error-free counting. A single injected bit shows both the one-bit inversion at the exact position and the one-count error response. A burst of 20 corrupted bits separates loss of lock from mere error counting. A long run of sparse injections drives both counters into saturation, and a sweep over all eight rate steps checks the strobe spacing.

// File: rtl/prbs_bert_pkg.sv
package prbs_bert_pkg;

  localparam int LFSR_W = 23;
  localparam logic [LFSR_W-1:0] LFSR_SEED = '1;

  function automatic int unsigned tap_far(input logic [1:0] sel);
    case (sel)
      2'b00:   return 9;
      2'b01:   return 15;
      default: return 23;
    endcase
  endfunction

  function automatic int unsigned tap_near(input logic [1:0] sel);
    case (sel)
      2'b00:   return 5;
      2'b01:   return 14;
      default: return 18;
    endcase
  endfunction

  // Fibonacci feedback: bit 0 holds the newest bit.
  function automatic logic lfsr_fb(input logic [LFSR_W-1:0] st, input logic [1:0] sel);
    return st[tap_far(sel)-1] ^ st[tap_near(sel)-1];
  endfunction

endpackage

// File: rtl/bert_rate_div.sv
module bert_rate_div #(
  parameter int LEVELS   = 8,
  parameter int DIV_STEP = 4,
  localparam int SW = $clog2(LEVELS),
  localparam int CW = $clog2(LEVELS * DIV_STEP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] rate_sel,
  output logic          strobe
);

  logic [CW-1:0] cnt_q, cnt_d, period;

  always_comb begin
    period = CW'((LEVELS - int'(rate_sel)) * DIV_STEP);
    strobe = (cnt_q >= period - CW'(1));
    cnt_d  = strobe ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/bert_prbs_gen.sv
module bert_prbs_gen
  import prbs_bert_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       strobe,
  input  logic [1:0] pattern_sel,
  input  logic       inject,
  output logic       tx_data,
  output logic       tx_valid,
  output logic       pend
);

  logic [LFSR_W-1:0] st_q, st_d;
  logic pend_q, pend_d, data_q, data_d, valid_q, valid_d, fb;

  always_comb begin
    fb      = lfsr_fb(st_q, pattern_sel);
    st_d    = st_q;
    data_d  = data_q;
    valid_d = 1'b0;
    pend_d  = pend_q | inject;
    if (restart) begin
      st_d = LFSR_SEED;
    end else if (strobe) begin
      st_d    = {st_q[LFSR_W-2:0], fb};
      data_d  = fb ^ pend_d;
      valid_d = 1'b1;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= LFSR_SEED;
      pend_q  <= 1'b0;
      data_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pend_q  <= pend_d;
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  assign tx_data  = data_q;
  assign tx_valid = valid_q;
  assign pend     = pend_q;

endmodule

// File: rtl/bert_prbs_chk.sv
module bert_prbs_chk
  import prbs_bert_pkg::*;
#(
  parameter int LOCK_RUN  = 32,
  parameter int LOSS_WIN  = 64,
  parameter int LOSS_ERRS = 8,
  localparam int RW = $clog2(LOCK_RUN + 1),
  localparam int WW = $clog2(LOSS_WIN),
  localparam int EW = $clog2(LOSS_ERRS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [1:0] pattern_sel,
  input  logic       rx_data,
  input  logic       rx_valid,
  output logic       locked,
  output logic       cnt_en,
  output logic       cnt_miss
);

  logic [LFSR_W-1:0] sh_q, sh_d;
  logic [RW-1:0] run_q, run_d;
  logic [WW-1:0] win_q, win_d;
  logic [EW-1:0] errs_q, errs_d;
  logic lock_q, lock_d, pred, miss;

  always_comb begin
    pred   = lfsr_fb(sh_q, pattern_sel);
    miss   = (pred != rx_data);
    sh_d   = sh_q;
    run_d  = run_q;
    win_d  = win_q;
    errs_d = errs_q;
    lock_d = lock_q;
    if (restart) begin
      lock_d = 1'b0;
      run_d  = '0;
      win_d  = '0;
      errs_d = '0;
    end else if (rx_valid) begin
      if (!lock_q) begin
        // Hunting: self-synchronise on the received bits.
        sh_d = {sh_q[LFSR_W-2:0], rx_data};
        if (miss) begin
          run_d = '0;
        end else if (run_q == RW'(LOCK_RUN - 1)) begin
          lock_d = 1'b1;
          run_d  = '0;
          win_d  = '0;
          errs_d = '0;
        end else begin
          run_d = run_q + RW'(1);
        end
      end else begin
        // Locked: free-run on predictions so one bad bit counts once.
        sh_d = {sh_q[LFSR_W-2:0], pred};
        if (miss && errs_q == EW'(LOSS_ERRS - 1)) begin
          lock_d = 1'b0;
          run_d  = '0;
        end else if (win_q == WW'(LOSS_WIN - 1)) begin
          win_d  = '0;
          errs_d = '0;
        end else begin
          win_d  = win_q + WW'(1);
          errs_d = errs_q + EW'(miss);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      run_q  <= '0;
      win_q  <= '0;
      errs_q <= '0;
      lock_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      run_q  <= run_d;
      win_q  <= win_d;
      errs_q <= errs_d;
      lock_q <= lock_d;
    end
  end

  assign locked   = lock_q;
  assign cnt_en   = rx_valid & lock_q;
  assign cnt_miss = miss;

endmodule

// File: rtl/bert_sat_cnt.sv
module bert_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                    cnt_d = '0;
    else if (inc && cnt_q != '1) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/prbs_bert_core.sv
module prbs_bert_core #(
  parameter int CNT_W     = 32,
  parameter int DIV_STEP  = 4,
  parameter int LOCK_RUN  = 32,
  parameter int LOSS_WIN  = 64,
  parameter int LOSS_ERRS = 8,
  localparam int RATE_LEVELS = 8,
  localparam int RSW = $clog2(RATE_LEVELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       pattern_sel,
  input  logic [RSW-1:0]   rate_sel,
  input  logic             inject,
  output logic             tx_data,
  output logic             tx_valid,
  input  logic             rx_data,
  input  logic             rx_valid,
  input  logic             clr_counts,
  output logic             locked,
  output logic [CNT_W-1:0] err_count,
  output logic [CNT_W-1:0] bit_count
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic [1:0] pat_q;
  logic       restart, bit_stb, inj_pend, cnt_en, cnt_miss;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pat_q <= '0;
    else             pat_q <= pattern_sel;
  end
  assign restart = (pat_q != pattern_sel);

  bert_rate_div #(.LEVELS(RATE_LEVELS), .DIV_STEP(DIV_STEP)) div_i (
    .clk(clk), .rst_n(rst_sync_n), .rate_sel(rate_sel), .strobe(bit_stb)
  );

  bert_prbs_gen gen_i (
    .clk(clk), .rst_n(rst_sync_n), .restart(restart), .strobe(bit_stb),
    .pattern_sel(pattern_sel), .inject(inject),
    .tx_data(tx_data), .tx_valid(tx_valid), .pend(inj_pend)
  );

  bert_prbs_chk #(.LOCK_RUN(LOCK_RUN), .LOSS_WIN(LOSS_WIN), .LOSS_ERRS(LOSS_ERRS)) chk_i (
    .clk(clk), .rst_n(rst_sync_n), .restart(restart), .pattern_sel(pattern_sel),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .locked(locked), .cnt_en(cnt_en), .cnt_miss(cnt_miss)
  );

  bert_sat_cnt #(.W(CNT_W)) bits_i (
    .clk(clk), .rst_n(rst_sync_n), .clr(clr_counts), .inc(cnt_en), .count(bit_count)
  );

  bert_sat_cnt #(.W(CNT_W)) errs_i (
    .clk(clk), .rst_n(rst_sync_n), .clr(clr_counts), .inc(cnt_en & cnt_miss), .count(err_count)
  );

endmodule

// File: rtl/bert_sva.sv
module bert_sva #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             locked,
  input logic             restart,
  input logic             inject,
  input logic             pend,
  input logic             strobe,
  input logic [CNT_W-1:0] bit_count,
  input logic [CNT_W-1:0] err_count
);

  p_frozen_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !clr) |=> ($stable(bit_count) && $stable(err_count)));

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && bit_count != '0) |=> (bit_count != '0));

  p_err_le_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_count <= bit_count);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bit_count == '0 && err_count == '0));

  p_unlock_on_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !locked);

  p_inject_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((inject || pend) && !strobe) |=> pend);

endmodule

bind prbs_bert_core bert_sva #(.CNT_W(CNT_W)) sva_i (
  .clk(clk), .rst_n(rst_sync_n), .clr(clr_counts), .locked(locked),
  .restart(restart), .inject(inject), .pend(inj_pend), .strobe(bit_stb),
  .bit_count(bit_count), .err_count(err_count)
);

// File: tb/prbs_bert_core_tb.sv
`timescale 1ns/1ps
module prbs_bert_core_tb_top;

  localparam int CW = 8;
  localparam int DS = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] pattern_sel;
  logic [2:0] rate_sel;
  logic inject, clr_counts, flip;
  logic tx_data, tx_valid, rx_data, rx_valid, locked;
  logic [CW-1:0] err_count, bit_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [22:0] m_st;

  always #4 clk = ~clk;

  assign rx_data  = tx_data ^ flip;
  assign rx_valid = tx_valid;

  prbs_bert_core #(.CNT_W(CW), .DIV_STEP(DS)) dut_i (
    .clk(clk), .rst_n(rst_n), .pattern_sel(pattern_sel), .rate_sel(rate_sel),
    .inject(inject), .tx_data(tx_data), .tx_valid(tx_valid),
    .rx_data(rx_data), .rx_valid(rx_valid), .clr_counts(clr_counts),
    .locked(locked), .err_count(err_count), .bit_count(bit_count)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int far_tap(input logic [1:0] s);
    return (s == 2'b00) ? 9 : (s == 2'b01) ? 15 : 23;
  endfunction
  function automatic int near_tap(input logic [1:0] s);
    return (s == 2'b00) ? 5 : (s == 2'b01) ? 14 : 18;
  endfunction

  // b[n] = b[n-far] ^ b[n-near], history all ones at start
  task automatic model_bit(input logic [1:0] s, output logic b);
    b = m_st[far_tap(s)-1] ^ m_st[near_tap(s)-1];
    m_st = {m_st[21:0], b};
  endtask

  task automatic wait_tx(output logic d);
    do @(negedge clk); while (!tx_valid);
    d = tx_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic d, e;
    int mism, first_bad, n, tally;
    logic [CW-1:0] bc_hold;
    rst_n = 1'b0; pattern_sel = 2'b00; rate_sel = 3'd7;
    inject = 1'b0; clr_counts = 1'b0; flip = 1'b0;
    repeat (4) @(negedge clk);
    // R11 reset state
    check(tx_valid == 1'b0, "R11 tx_valid", tx_valid, 0);
    check(locked == 1'b0, "R11 locked", locked, 0);
    check(err_count == 0 && bit_count == 0, "R11 counters", bit_count, 0);
    rst_n = 1'b1;

    // R1 short order over more than one full period, R4 lock on loopback
    m_st = '1; mism = 0;
    for (int i = 0; i < 600; i++) begin
      wait_tx(d); model_bit(2'b00, e);
      if (d !== e) mism++;
    end
    check(mism == 0, "R1 order-9 stream", mism, 0);
    check(locked == 1'b1, "R4 lock on clean loopback", locked, 1);
    check(err_count == 0, "R5 no errors on clean stream", err_count, 0);

    // R2 rate sweep
    for (int l = 0; l < 8; l++) begin
      rate_sel = 3'(l);
      wait_tx(d); wait_tx(d);
      n = 0;
      do begin @(negedge clk); n++; end while (!tx_valid);
      check(n == (8 - l) * DS, $sformatf("R2 spacing level %0d", l), n, (8 - l) * DS);
    end
    rate_sel = 3'd7;

    // R9 clear, R7 exact bit count while locked
    @(negedge clk); clr_counts = 1'b1;
    @(negedge clk); clr_counts = 1'b0;
    check(bit_count == 0 && err_count == 0, "R9 clear", bit_count, 0);
    tally = int'(rx_valid);
    for (int i = 0; i < 199; i++) begin
      @(negedge clk); tally += int'(rx_valid);
    end
    @(negedge clk);
    check(int'(bit_count) == tally, "R7 bit count while locked", bit_count, tally);

    // R10 pattern change: unlock, reseed; R7 frozen while hunting
    check(locked == 1'b1, "R10 locked before change", locked, 1);
    @(negedge clk); pattern_sel = 2'b01;
    @(negedge clk);
    check(locked == 1'b0, "R10 unlock on pattern change", locked, 0);
    bc_hold = bit_count;
    m_st = '1; mism = 0; first_bad = -1;
    for (int i = 0; i < 300; i++) begin
      if (i == 150) begin
        inject = 1'b1; @(negedge clk); inject = 1'b0;
      end
      wait_tx(d); model_bit(2'b01, e);
      if (d !== e) begin mism++; if (first_bad < 0) first_bad = i; end
      if (i == 10) check(bit_count == bc_hold, "R7 frozen while unlocked", bit_count, bc_hold);
    end
    check(mism == 1, "R3 exactly one inverted bit", mism, 1);
    check(first_bad == 150, "R3 inverted bit position", first_bad, 150);
    check(err_count == 1, "R5 one error per injected bit", err_count, 1);

    // R6 loss of lock under an error burst, then relock
    flip = 1'b1;
    for (int i = 0; i < 20; i++) wait_tx(d);
    flip = 1'b0;
    @(negedge clk);
    check(locked == 1'b0, "R6 lock lost after burst", locked, 0);
    for (int i = 0; i < 200; i++) wait_tx(d);
    check(locked == 1'b1, "R6 relock on clean stream", locked, 1);

    // R1 long order
    @(negedge clk); pattern_sel = 2'b10;
    m_st = '1; mism = 0;
    for (int i = 0; i < 400; i++) begin
      wait_tx(d); model_bit(2'b10, e);
      if (d !== e) mism++;
    end
    check(mism == 0, "R1 order-23 stream", mism, 0);
    check(locked == 1'b1, "R4 lock on long order", locked, 1);

    // R8 saturation of both counters under sparse injection
    @(negedge clk); clr_counts = 1'b1;
    @(negedge clk); clr_counts = 1'b0;
    for (int i = 0; i < 4300; i++) begin
      wait_tx(d);
      if (i % 16 == 0) begin
        inject = 1'b1; @(negedge clk); inject = 1'b0;
      end
    end
    check(bit_count == 8'hFF, "R8 bit count saturates", bit_count, 255);
    check(err_count == 8'hFF, "R8 error count saturates", err_count, 255);

    // R9 clear from saturation
    @(negedge clk); clr_counts = 1'b1;
    @(negedge clk); clr_counts = 1'b0;
    check(bit_count == 0 && err_count == 0, "R9 clear from full", err_count, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule